// File: doc/BRIEF.md
# Accumulator Store Shifter

This block sits on the store path of a 32-bit accumulator. When a store is requested it shifts the accumulator left by 0 to 7 places and picks one 16-bit half to send to data memory. The shift happens only on the copy that is stored. The accumulator value at the input is never changed by the block.

For the upper half, the bits pushed out at the top are dropped. The vacated low positions take the top bits of the lower half, so the upper half is a 16-bit window of the accumulator. For the lower half, the vacated low positions fill with zeros. A full 32-bit value goes to memory as two separate stores, one for each half. Both stores use the same shift count.

The result is registered. The store word and its valid flag appear one clock after the strobe.

Top module: `acc_store_shifter`

## Requirements
- R1: After reset, `st_valid` is 0 and `st_word` is 0.
- R2: `st_valid` is 1 in the cycle after a cycle with `st_req`=1, and 0 in the cycle after a cycle with `st_req`=0.
- R3: With `st_hi`=1 and shift n=`st_shift`, `st_word` equals `acc_in[31-n:16-n]`. Bits moved above bit 31 are lost, and the low bits of the word come from the top of the lower half.
- R4: With `st_hi`=0 and shift n, `st_word` equals `acc_in[15-n:0]` followed by n zero bits.
- R5: With `st_shift`=0, the stored word is exactly the selected half: bits 31..16 when `st_hi`=1, bits 15..0 when `st_hi`=0.
- R6: When `st_req`=0, `st_word` keeps its last value, whatever `acc_in`, `st_shift` and `st_hi` do.
- R7: With `st_shift`=7 and `st_hi`=0, bits 6..0 of `st_word` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_in | input | 32 | Accumulator value (read only) |
| st_shift | input | 3 | Left shift count, 0 to 7 |
| st_hi | input | 1 | 1 selects the upper half, 0 the lower half |
| st_req | input | 1 | Store strobe |
| st_word | output | 16 | Shifted store word |
| st_valid | output | 1 | Store word valid, one cycle after the strobe |

## Verification
Three kinds of accumulator value are swept over every shift count and both halves:
- A single walking one, which shows exactly which source bit lands where. It also catches a wrong fill direction or an off-by-one window.
- All ones, which separates a zero fill from a fill taken out of the lower half.
- Values with distinct, alternating patterns in each half, which reveal swapped halves.

Idle cycles with changing inputs confirm that the word holds between strobes.

// File: rtl/acc_store_pkg.sv
package acc_store_pkg;
  localparam int ACC_W = 32;
  localparam int HALF_W = ACC_W / 2;
  localparam int SH_W = 3;

  typedef enum logic {HALF_LO = 1'b0, HALF_HI = 1'b1} half_e;

  // Upper-half window of acc shifted left by n; low positions are refilled from the lower half
  function automatic logic [HALF_W-1:0] hi_window(input logic [ACC_W-1:0] acc,
                                                  input logic [SH_W-1:0] n);
    logic [ACC_W-1:0] s;
    s = acc << n;
    return s[ACC_W-1:HALF_W];
  endfunction

  // Lower half shifted left by n, zero filled
  function automatic logic [HALF_W-1:0] lo_window(input logic [ACC_W-1:0] acc,
                                                  input logic [SH_W-1:0] n);
    return acc[HALF_W-1:0] << n;
  endfunction
endpackage

// File: rtl/acc_shift_core.sv
module acc_shift_core
  import acc_store_pkg::*;
(
  input  logic [ACC_W-1:0]  acc,
  input  logic [SH_W-1:0]   shamt,
  input  half_e             half,
  output logic [HALF_W-1:0] word
);
  logic [HALF_W-1:0] hi_w, lo_w;
  assign hi_w = hi_window(acc, shamt);
  assign lo_w = lo_window(acc, shamt);
  assign word = (half == HALF_HI) ? hi_w : lo_w;
endmodule

// File: rtl/acc_store_reg.sv
module acc_store_reg
  import acc_store_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [HALF_W-1:0] d,
  output logic [HALF_W-1:0] q,
  output logic              vld
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q   <= '0;
      vld <= 1'b0;
    end else begin
      vld <= load;
      if (load) q <= d;
    end
  end
endmodule

// File: rtl/acc_store_shifter.sv
module acc_store_shifter
  import acc_store_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [31:0]       acc_in,
  input  logic [2:0]        st_shift,
  input  logic              st_hi,
  input  logic              st_req,
  output logic [15:0]       st_word,
  output logic              st_valid
);
  logic [HALF_W-1:0] shifted_word;  // named event wire for checker
  logic              store_fire;

  assign store_fire = st_req;

  acc_shift_core u_core (
    .acc   (acc_in),
    .shamt (st_shift),
    .half  (half_e'(st_hi)),
    .word  (shifted_word)
  );

  acc_store_reg u_reg (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (store_fire),
    .d     (shifted_word),
    .q     (st_word),
    .vld   (st_valid)
  );
endmodule

module acc_store_shifter_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [31:0] acc_in,
  input logic [2:0]  st_shift,
  input logic        st_hi,
  input logic        st_req,
  input logic [15:0] st_word,
  input logic        st_valid
);
  assert_valid_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    st_req |=> st_valid);
  assert_valid_drops_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !st_req |=> !st_valid);
  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!st_req && $past(rst_n)) |=> $stable(st_word));
  assert_zero_fill_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (st_req && !st_hi && st_shift == 3'd7) |=> (st_word[6:0] == 7'd0));
  assert_unshifted_hi_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (st_req && st_hi && st_shift == 3'd0) |=> (st_word == $past(acc_in[31:16])));
  assert_unshifted_lo_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (st_req && !st_hi && st_shift == 3'd0) |=> (st_word == $past(acc_in[15:0])));
endmodule

bind acc_store_shifter acc_store_shifter_chk u_chk (
  .clk(clk), .rst_n(rst_n), .acc_in(acc_in), .st_shift(st_shift),
  .st_hi(st_hi), .st_req(st_req), .st_word(st_word), .st_valid(st_valid)
);

// File: tb/acc_store_shifter_test.sv
module acc_store_shifter_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] acc_in = '0;
  logic [2:0]  st_shift = '0;
  logic        st_hi = 1'b0;
  logic        st_req = 1'b0;
  logic [15:0] st_word;
  logic        st_valid;
  int checks = 0;
  int fails = 0;

  always #4 clk = ~clk;  // 125 MHz

  acc_store_shifter uut (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Expected result by bit-by-bit arithmetic, independent of RTL
  function automatic logic [15:0] model(input logic [31:0] a, input int n, input logic hi);
    logic [15:0] r;
    for (int b = 0; b < 16; b++) begin
      int src;
      src = (hi ? b + 16 : b) - n;
      r[b] = (src < 0) ? 1'b0 : (hi ? a[src] : (src < 16 ? a[src] : 1'b0));
    end
    return r;
  endfunction

  task automatic do_store(input logic [31:0] a, input int n, input logic hi);
    string tag;
    @(negedge clk);
    acc_in = a; st_shift = 3'(n); st_hi = hi; st_req = 1'b1;
    @(negedge clk);
    st_req = 1'b0;
    tag = hi ? "R3" : "R4";
    if (n == 0) tag = "R5";
    else if (n == 7 && !hi) tag = "R7";
    check(tag, {16'd0, st_word}, {16'd0, model(a, n, hi)});
    check("R2", {31'd0, st_valid}, 32'd1);
  endtask

  initial begin
    logic [15:0] held;
    fork
      begin
        repeat (100000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
      begin
        repeat (3) @(negedge clk);
        check("R1", {16'd0, st_word}, 32'd0);
        check("R1", {31'd0, st_valid}, 32'd0);
        rst_n = 1'b1;
        for (int n = 0; n < 8; n++)
          for (int h = 0; h < 2; h++) begin
            for (int b = 0; b < 32; b++) do_store(32'd1 << b, n, h[0]);
            do_store(32'hFFFF_FFFF, n, h[0]);
            do_store(32'hA5C3_5A3C, n, h[0]);
            do_store(32'h0F0F_F0F0, n, h[0]);
          end
        // R7: low store, shift 7, all ones
        do_store(32'h0000_FFFF, 7, 1'b0);
        check("R7", {16'd0, st_word}, 32'h0000_FF80);
        // R6 hold and R2 valid drop
        held = st_word;
        for (int k = 0; k < 10; k++) begin
          @(negedge clk);
          acc_in = 32'h1234_5678 * (k + 3); st_shift = 3'(k); st_hi = k[0];
          @(negedge clk);
          check("R6", {16'd0, st_word}, {16'd0, held});
          check("R2", {31'd0, st_valid}, 32'd0);
        end
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule